// File: doc/BRIEF.md
# Control-Byte SPI Command Slave

This block is the serial slave that sits between a host controller and a command/response core. A host opens a transaction by pulling the enable line low and clocking in one control byte. That byte decides what happens next. It can start an eight-byte command write. It can also start a read of either the status byte alone or the full sixteen-byte response, and the read data leaves on either the shared data line or a secondary output pin. The enable, serial clock and data inputs are oversampled by the system clock through synchronizers, and all decisions are made on the detected clock edges.

Received command bytes are collected into a buffer. They are handed to the core with a single-cycle strobe, but only when the host delivered exactly eight bytes before raising the enable line. Any other length counts as an abort, and the command is dropped. Read data is fetched live from a flat response vector that the core holds. A strap pair sampled on the first clock after reset release selects the bus mode. This block responds only when the strap selects SPI.

Top module: `spi_cmd_slave`

## Requirements
- R1: On the first clock after reset release, the block captures `strap_a`/`strap_b`. Only 1/1 (SPI) enables it. With 1/0 (two-wire), 0/0 (three-wire) or 0/1, it never drives an output enable and never strobes `cmd_valid`. Strap changes after capture have no effect.
- R2: A transaction starts when `spi_sen` falls. The next eight `spi_sclk` rising edges sample the control byte, most significant bit first.
- R3: Control byte 0x48 is a command write. The bits that follow fill command byte k into `cmd_data[8k+7:8k]`, most significant bit first, with the command itself as byte 0. When `spi_sen` rises after exactly 64 data bits, `cmd_valid` pulses high for one clock.
- R4: A write that ends with any bit count other than 64 produces no `cmd_valid` pulse.
- R5: Four control bytes select a read. 0x80 reads 1 byte on `sdio_out`, 0xC0 reads 16 bytes on `sdio_out`, 0xA0 reads 1 byte on `aux_out`, and 0xE0 reads 16 bytes on `aux_out`. Byte k is `resp_data[8k+7:8k]`, with byte 0 as the status byte, sent most significant bit first.
- R6: Read data changes only after `spi_sclk` falling edges. The first bit appears after the falling edge that follows the eighth control rising edge, and it is stable across the following rising edge.
- R7: The output enable drops on the falling edge that follows the last read bit, and it also drops once `spi_sen` is high.
- R8: Any other control byte is ignored. No output enable is raised and no strobe is produced for the rest of that transaction, whatever follows.
- R9: `spi_sclk` activity while `spi_sen` is high has no effect.
- R10: After reset, both output enables and `cmd_valid` are low. The pin that a read does not select keeps its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a | input | 1 | Bus-mode strap, first bit |
| strap_b | input | 1 | Bus-mode strap, second bit |
| spi_sen | input | 1 | Active-low transaction enable |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| resp_data | input | RESP_BYTES*8 | Response buffer, byte 0 is status |
| sdio_out | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| aux_out | output | 1 | Read data for the secondary pin |
| aux_oe | output | 1 | Drive enable for the secondary pin |
| cmd_valid | output | 1 | One-clock strobe for a complete command |
| cmd_data | output | CMD_BYTES*8 | Collected command bytes, byte 0 is the command |

## Verification
The bench goes after the length edges of a command write. It ends writes at 56, 64 and 72 bits and also aborts part-way through a byte. A design that counted bytes loosely would strobe a truncated or overrun command. It reads every one of the four read codes against fresh random response data and samples each bit both before and after the rising edge. A design that updated on the wrong edge, mixed up the pins, or let the enable linger past the last bit would show a wrong byte or a stray enable. Control bytes that differ from the valid codes by one bit, clock activity with the enable high, and non-SPI straps are all checked at the pins for silence.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } xfer_state_e;

    typedef enum logic [1:0] {
        BUS_TWO,
        BUS_SPI,
        BUS_THREE,
        BUS_NONE
    } bus_mode_e;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_READ,
        OP_BAD
    } ctrl_op_e;

    localparam logic [7:0] CODE_CMD_WRITE  = 8'h48;
    localparam logic [7:0] CODE_RD_SHORT   = 8'h80;
    localparam logic [7:0] CODE_RD_LONG    = 8'hC0;
    localparam logic [7:0] CODE_RDX_SHORT  = 8'hA0;
    localparam logic [7:0] CODE_RDX_LONG   = 8'hE0;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= INIT;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{INIT}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic [7:0] code,
    output ctrl_op_e   op,
    output logic       long_rd,
    output logic       use_aux
);
    always_comb begin
        op      = OP_BAD;
        long_rd = 1'b0;
        use_aux = 1'b0;
        case (code)
            CODE_CMD_WRITE: op = OP_WRITE;
            CODE_RD_SHORT:  op = OP_READ;
            CODE_RD_LONG: begin
                op      = OP_READ;
                long_rd = 1'b1;
            end
            CODE_RDX_SHORT: begin
                op      = OP_READ;
                use_aux = 1'b1;
            end
            CODE_RDX_LONG: begin
                op      = OP_READ;
                long_rd = 1'b1;
                use_aux = 1'b1;
            end
            default: op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int CMD_BYTES   = 8,
    parameter int RESP_BYTES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strap_a,
    input  logic                    strap_b,
    input  logic                    spi_sen,
    input  logic                    spi_sclk,
    input  logic                    spi_sdi,
    input  logic [RESP_BYTES*8-1:0] resp_data,
    output logic                    sdio_out,
    output logic                    sdio_oe,
    output logic                    aux_out,
    output logic                    aux_oe,
    output logic                    cmd_valid,
    output logic [CMD_BYTES*8-1:0]  cmd_data
);
    localparam int CMD_BITS   = CMD_BYTES * 8;
    localparam int RESP_BITS  = RESP_BYTES * 8;
    localparam int MAX_BITS   = (RESP_BITS > CMD_BITS) ? RESP_BITS : CMD_BITS;
    localparam int CW         = $clog2(MAX_BITS + 2);
    localparam int CIW        = $clog2(CMD_BITS);
    localparam int RIW        = $clog2(RESP_BITS);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(7);
    localparam logic [CW-1:0] CNT_CMD   = CW'(CMD_BITS);
    localparam logic [CW-1:0] CNT_LONG  = CW'(RESP_BITS);
    localparam logic [CW-1:0] CNT_SHORT = CW'(8);
    localparam logic [2:0]    SYNC_INIT = 3'b100;

    typedef struct packed {
        logic                captured;
        bus_mode_e           bus;
        xfer_state_e         st;
        logic [CW-1:0]       cnt;
        logic [7:0]          ctrl_sh;
        logic                long_rd;
        logic                use_aux;
        logic                sclk_prev;
        logic [CMD_BITS-1:0] cmd_buf;
        logic                out_bit;
        logic                drive;
        logic                cmd_valid;
    } regs_t;

    regs_t q, d;

    // Synchronizers for enable, clock and data (enable idles high)
    logic [2:0] pin_raw;
    logic [2:0] pin_s;
    assign pin_raw = {spi_sen, spi_sclk, spi_sdi};

    generate
        for (genvar g = 0; g < 3; g++) begin : g_sync
            spi_cmd_sync #(
                .STAGES (SYNC_STAGES),
                .INIT   (SYNC_INIT[g])
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_raw[g]),
                .q     (pin_s[g])
            );
        end
    endgenerate

    logic sen_s, sclk_s, sdi_s;
    logic sclk_rise, sclk_fall;
    logic spi_active;
    assign sen_s      = pin_s[2];
    assign sclk_s     = pin_s[1];
    assign sdi_s      = pin_s[0];
    assign sclk_rise  = sclk_s & ~q.sclk_prev;
    assign sclk_fall  = ~sclk_s & q.sclk_prev;
    assign spi_active = q.captured && (q.bus == BUS_SPI);

    // Decode of the byte completed by the current rising edge
    ctrl_op_e dec_op;
    logic     dec_long, dec_aux;
    spi_cmd_decode u_decode (
        .code    ({q.ctrl_sh[6:0], sdi_s}),
        .op      (dec_op),
        .long_rd (dec_long),
        .use_aux (dec_aux)
    );

    logic [CIW-1:0] wr_idx;
    logic [RIW-1:0] rd_idx;
    logic [CW-1:0]  rd_len;
    assign wr_idx = {q.cnt[CIW-1:3], ~q.cnt[2:0]};
    assign rd_idx = {q.cnt[RIW-1:3], ~q.cnt[2:0]};
    assign rd_len = q.long_rd ? CNT_LONG : CNT_SHORT;

    always_comb begin
        d           = q;
        d.cmd_valid = 1'b0;
        d.sclk_prev = sclk_s;

        if (!q.captured) begin
            d.captured = 1'b1;
            case ({strap_a, strap_b})
                2'b10:   d.bus = BUS_TWO;
                2'b11:   d.bus = BUS_SPI;
                2'b00:   d.bus = BUS_THREE;
                default: d.bus = BUS_NONE;
            endcase
        end

        if (!spi_active) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else if (sen_s) begin
            if (q.st == ST_WRITE && q.cnt == CNT_CMD) begin
                d.cmd_valid = 1'b1;
            end
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    d.st  = ST_CTRL;
                    d.cnt = '0;
                end
                ST_CTRL: begin
                    if (sclk_rise) begin
                        d.ctrl_sh = {q.ctrl_sh[6:0], sdi_s};
                        if (q.cnt == CNT_LAST) begin
                            d.cnt = '0;
                            case (dec_op)
                                OP_WRITE: d.st = ST_WRITE;
                                OP_READ: begin
                                    d.st      = ST_READ;
                                    d.long_rd = dec_long;
                                    d.use_aux = dec_aux;
                                end
                                default: d.st = ST_SKIP;
                            endcase
                        end else begin
                            d.cnt = q.cnt + CNT_ONE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (sclk_rise && q.cnt <= CNT_CMD) begin
                        if (q.cnt < CNT_CMD) begin
                            d.cmd_buf[wr_idx] = sdi_s;
                        end
                        d.cnt = q.cnt + CNT_ONE;
                    end
                end
                ST_READ: begin
                    if (sclk_fall) begin
                        if (q.cnt < rd_len) begin
                            d.out_bit = resp_data[rd_idx];
                            d.drive   = 1'b1;
                            d.cnt     = q.cnt + CNT_ONE;
                        end else begin
                            d.drive = 1'b0;
                        end
                    end
                end
                default: d.drive = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdio_out  = q.out_bit;
    assign aux_out   = q.out_bit;
    assign sdio_oe   = q.drive & ~q.use_aux;
    assign aux_oe    = q.drive & q.use_aux;
    assign cmd_valid = q.cmd_valid;
    assign cmd_data  = q.cmd_buf;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sen_s,
    input logic sclk_fall,
    input logic spi_active,
    input logic sdio_out,
    input logic sdio_oe,
    input logic aux_out,
    input logic aux_oe,
    input logic cmd_valid
);
    p_quiet_inactive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_active |-> (!sdio_oe && !aux_oe && !cmd_valid));

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_strobe_after_sen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(sen_s));

    p_change_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sclk_fall) |-> ($stable(sdio_out) && $stable(aux_out)));

    p_release_on_sen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> (!sdio_oe && !aux_oe));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sen_s      (sen_s),
    .sclk_fall  (sclk_fall),
    .spi_active (spi_active),
    .sdio_out   (sdio_out),
    .sdio_oe    (sdio_oe),
    .aux_out    (aux_out),
    .aux_oe     (aux_oe),
    .cmd_valid  (cmd_valid)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
    localparam int CB = 8;
    localparam int RB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_a = 1'b1, strap_b = 1'b1;
    logic sen = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [RB*8-1:0] resp = '0;
    logic sdio_out, sdio_oe, aux_out, aux_oe, cmd_valid;
    logic [CB*8-1:0] cmd_data;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    logic [CB*8-1:0] last_cmd = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_cmd_slave #(.CMD_BYTES(CB), .RESP_BYTES(RB), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
        .spi_sen(sen), .spi_sclk(sclk), .spi_sdi(sdi), .resp_data(resp),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .aux_out(aux_out), .aux_oe(aux_oe),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes  = strobes + 1;
            last_cmd = cmd_data;
        end
    end

    function automatic logic [7:0] resp_byte(input logic [RB*8-1:0] r, input int k);
        return r[k*8 +: 8];
    endfunction

    function automatic logic stream_bit(input logic [71:0] s, input int i);
        return s[(i/8)*8 + 7 - (i%8)];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(input logic a, input logic b);
        rst_n = 1'b0; sen = 1'b1; sclk = 1'b0;
        strap_a = a; strap_b = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic begin_txn(input logic [7:0] ctrl);
        sen = 1'b0;
        half();
        for (int i = 0; i < 8; i++) begin
            sdi = ctrl[7-i];
            half();
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
    endtask

    task automatic end_txn();
        half();
        sen = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Command write with a chosen number of data bits
    task automatic do_write(input int nbits, input logic [71:0] s, input string req);
        int s0;
        begin_txn(8'h48);
        for (int i = 0; i < nbits; i++) begin
            sdi = stream_bit(s, i);
            half();
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        s0 = strobes;
        end_txn();
        if (nbits == 64) begin
            chk(strobes - s0 == 1, req, 64'(strobes - s0), 64'd1);
            chk(last_cmd == s[63:0], req, last_cmd, s[63:0]);
        end else begin
            chk(strobes == s0, req, 64'(strobes - s0), 64'd0);
        end
    endtask

    // Read with one of the four valid codes
    task automatic do_read(input logic [7:0] ctrl);
        bit aux_pin, long_rd, oe_bad, moved;
        int nb;
        logic [7:0] got;
        logic b_pre;
        aux_pin = ctrl[5];
        long_rd = ctrl[6];
        nb = long_rd ? RB : 1;
        begin_txn(ctrl);
        for (int k = 0; k < nb; k++) begin
            oe_bad = 1'b0; moved = 1'b0; got = '0;
            for (int j = 0; j < 8; j++) begin
                half();
                b_pre = aux_pin ? aux_out : sdio_out;
                if (aux_pin ? (!aux_oe || sdio_oe) : (!sdio_oe || aux_oe)) oe_bad = 1'b1;
                got = {got[6:0], b_pre};
                sclk = 1'b1;
                half();
                if ((aux_pin ? aux_out : sdio_out) != b_pre) moved = 1'b1;
                sclk = 1'b0;
            end
            chk(got == resp_byte(resp, k), "R5 read byte", 64'(got), 64'(resp_byte(resp, k)));
            chk(!oe_bad, "R10 pin enables during read", 64'(oe_bad), 64'd0);
            chk(!moved, "R6 data stable over rising edge", 64'(moved), 64'd0);
        end
        half();
        chk(!sdio_oe && !aux_oe, "R7 enable drops after last bit", 64'({sdio_oe, aux_oe}), 64'd0);
        end_txn();
    endtask

    // Transaction that must produce no drive and no strobe
    task automatic quiet_txn(input logic [7:0] ctrl, input int nbits, input string req);
        bit seen;
        int s0;
        s0 = strobes;
        seen = 1'b0;
        begin_txn(ctrl);
        for (int i = 0; i < nbits; i++) begin
            sdi = 1'($urandom);
            half();
            if (sdio_oe || aux_oe) seen = 1'b1;
            sclk = 1'b1;
            half();
            if (sdio_oe || aux_oe) seen = 1'b1;
            sclk = 1'b0;
        end
        end_txn();
        chk(!seen, req, 64'(seen), 64'd0);
        chk(strobes == s0, req, 64'(strobes - s0), 64'd0);
    endtask

    function automatic logic [7:0] bad_code(input logic [7:0] c);
        logic [7:0] r;
        r = c;
        if (r == 8'h48 || r == 8'h80 || r == 8'hC0 || r == 8'hA0 || r == 8'hE0) r = r ^ 8'h01;
        return r;
    endfunction

    initial begin
        logic [71:0] s;
        int s0;
        bit seen;
        void'($urandom(32'h5eed_1234));

        // Non-SPI straps: block stays silent
        do_reset(1'b1, 1'b0);
        quiet_txn(8'h48, 64, "R1 two-wire strap write");
        quiet_txn(8'hC0, 128, "R1 two-wire strap read");
        do_reset(1'b0, 1'b0);
        quiet_txn(8'hE0, 128, "R1 three-wire strap read");

        // SPI straps
        do_reset(1'b1, 1'b1);
        chk(!sdio_oe && !aux_oe && !cmd_valid, "R10 reset state",
            64'({sdio_oe, aux_oe, cmd_valid}), 64'd0);
        strap_a = 1'b0; strap_b = 1'b0;   // post-capture change, R1

        s = {8'hAA, 64'h0123_4567_89AB_CDEF};
        do_write(64, s, "R3 exact command write");
        do_write(56, s, "R4 short write abort");
        do_write(72, s, "R4 long write abort");
        do_write(61, s, "R4 mid-byte abort");

        resp = {4{32'hC3A5_0F96}};
        do_read(8'h80);
        do_read(8'hC0);
        do_read(8'hA0);
        do_read(8'hE0);

        // R9: clock toggles with enable high
        s0 = strobes; seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            sdi = 1'($urandom);
            half(); sclk = 1'b1;
            half(); sclk = 1'b0;
            if (sdio_oe || aux_oe) seen = 1'b1;
        end
        chk(!seen && strobes == s0, "R9 clock with enable high", 64'(seen), 64'd0);
        do_read(8'hC0);   // R2 fresh transaction still framed correctly

        quiet_txn(8'h00, 128, "R8 unlisted code 00");
        quiet_txn(8'h49, 64,  "R8 unlisted code 49");
        quiet_txn(8'hC1, 128, "R8 unlisted code C1");

        // Random mix
        for (int n = 0; n < 24; n++) begin
            int kind;
            kind = int'($urandom % 4);
            resp = {$urandom, $urandom, $urandom, $urandom};
            s = {$urandom, $urandom, $urandom};
            case (kind)
                0: do_write(64, s, "R3 random write");
                1: do_write(int'($urandom % 72), s, "R4 random length write");
                2: begin
                    case ($urandom % 4)
                        0: do_read(8'h80);
                        1: do_read(8'hC0);
                        2: do_read(8'hA0);
                        default: do_read(8'hE0);
                    endcase
                end
                default: quiet_txn(bad_code(8'($urandom)), 24, "R8 random unlisted code");
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all: watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule